// File: doc/BRIEF.md
# Floating-Point to Integer Floor Converter

This block turns one IEEE-754 operand into a 32-bit integer, always rounding toward negative infinity. The operand arrives on a 64-bit bus together with a 2-bit format code that says whether it is a half, single or double precision value. Half and single operands occupy the low 16 or 32 bits, and the bits above them are ignored. A select bit chooses between an unsigned and a signed 32-bit result range.

The conversion is registered once: a request strobed with `in_valid` appears on the outputs in the following cycle with `out_valid` high. Values that fall outside the chosen range saturate to its nearest limit. NaNs produce zero. Every such case raises an invalid flag. A separate inexact flag reports that fraction bits were lost. A format code that names no supported precision raises a format error flag and leaves the result value untouched. Half precision can be removed at build time through a parameter.

Top module: `fp_floor_cvt`

## Requirements
- R1: A request with `in_valid` high is reflected on the outputs one clock later with `out_valid` high. In a cycle with `in_valid` low, `out_valid` is low on the next edge and `result` and the flags keep their values.
- R2: Format code 1 selects half precision from `operand[15:0]`, code 2 single precision from `operand[31:0]` and code 3 double precision from the whole bus. Bits above the selected width have no effect.
- R3: Format code 0 sets `flag_badfmt`, clears `flag_invalid` and `flag_inexact`, and leaves `result` at its previous value.
- R4: Rounding is toward negative infinity. A positive non-integer loses its fraction, and a negative non-integer becomes the next more negative integer.
- R5: When `is_signed` is 1, results above 0x7FFFFFFF return 0x7FFFFFFF and results below 0x80000000 return 0x80000000, with `flag_invalid` set. An exact -2^31 converts with no flag.
- R6: When `is_signed` is 0, results above 0xFFFFFFFF return 0xFFFFFFFF with `flag_invalid` set. Any input whose floor is below zero, -0.5 included, returns 0 with `flag_invalid` set. An input of -0.0 returns 0 with no flag.
- R7: A quiet or signalling NaN returns 0 with `flag_invalid` set.
- R8: An infinity returns the range limit that has the same sign, with `flag_invalid` set.
- R9: `flag_inexact` is 1 exactly when nonzero fraction bits were discarded and `flag_invalid` is 0.
- R10: Subnormal inputs convert exactly. A positive subnormal gives 0, and a negative subnormal gives 0xFFFFFFFF in signed mode. Both are inexact.
- R11: While `rst_n` is low, `out_valid`, `result` and all flags are 0.
- R12: When the parameter `HALF_EN` is 0, format code 1 behaves exactly as format code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Conversion request strobe |
| operand | input | 64 | Floating-point operand, right-aligned |
| fmt | input | 2 | Format code: 1 half, 2 single, 3 double, 0 invalid |
| is_signed | input | 1 | 1 signed 32-bit range, 0 unsigned |
| out_valid | output | 1 | Result and flags updated this cycle |
| result | output | 32 | Converted integer |
| flag_invalid | output | 1 | Saturation, NaN or negative unsigned result |
| flag_inexact | output | 1 | Fraction bits were discarded |
| flag_badfmt | output | 1 | Format code not supported |

## Verification
The vector table covers every precision with positive and negative fractional values, so truncation and flooring can be told apart. It also covers operands just inside and just outside each range limit, which separates exact limit values from saturated ones, and it repeats an operand in both signed and unsigned mode to show the effect of the range select. NaNs, infinities, signed zeros and subnormals of both signs check the special-class paths. Half and single operands padded with nonzero upper bits show that the bus alignment is correct. Directed steps check the format error hold, idle cycles, a second instance built without half precision, and a reset applied in the middle of a run.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

    localparam int RES_W = 32;
    localparam int OPD_W = 64;
    localparam int SIG_W = 53;
    localparam int EXP_W = 13;

    typedef enum logic [1:0] {
        FMT_NONE   = 2'd0,
        FMT_HALF   = 2'd1,
        FMT_SINGLE = 2'd2,
        FMT_DOUBLE = 2'd3
    } fmt_e;

    // Common unpacked form: value = sig * 2^(expo - (SIG_W-1))
    typedef struct packed {
        logic                    sign;
        logic signed [EXP_W-1:0] expo;
        logic [SIG_W-1:0]        sig;
        logic                    is_nan;
        logic                    is_inf;
    } unp_s;

    typedef struct packed {
        logic             vld;
        logic [RES_W-1:0] res;
        logic             inv;
        logic             inx;
        logic             bad;
    } out_s;

endpackage

// File: rtl/fcvt_field_split.sv
module fcvt_field_split
    import fcvt_pkg::*;
#(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic [EW+FW:0] bits_i,
    output unp_s           unp_o
);

    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam int PAD  = SIG_W - 1 - FW;

    logic [EW-1:0]    ef;
    logic [FW-1:0]    ff;
    logic             denorm;
    logic             emax;
    logic [SIG_W-1:0] sig_raw;

    always_comb begin
        ef      = bits_i[EW+FW-1:FW];
        ff      = bits_i[FW-1:0];
        denorm  = (ef == '0);
        emax    = &ef;
        sig_raw = SIG_W'({~denorm, ff});

        unp_o.sign   = bits_i[EW+FW];
        unp_o.sig    = sig_raw << PAD;
        // subnormals share the smallest normal exponent with a zero hidden bit
        unp_o.expo   = denorm ? EXP_W'(1 - BIAS) : EXP_W'(int'(ef) - BIAS);
        unp_o.is_nan = emax && (ff != '0);
        unp_o.is_inf = emax && (ff == '0);
    end

endmodule

// File: rtl/fcvt_floor_core.sv
module fcvt_floor_core
    import fcvt_pkg::*;
(
    input  unp_s             unp_i,
    input  logic             signed_i,
    output logic [RES_W-1:0] res_o,
    output logic             inv_o,
    output logic             inx_o
);

    localparam int SH_W = $clog2(SIG_W);
    localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(RES_W);
    localparam logic [RES_W:0] MAG_SMAX = {2'b00, {(RES_W-1){1'b1}}};
    localparam logic [RES_W:0] MAG_SMIN = {2'b01, {(RES_W-1){1'b0}}};
    localparam logic [RES_W-1:0] RES_SMAX = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] RES_SMIN = {1'b1, {(RES_W-1){1'b0}}};
    localparam logic [RES_W-1:0] RES_UMAX = {RES_W{1'b1}};

    logic             big;
    logic [SH_W-1:0]  shamt;
    logic [SIG_W-1:0] keep_mask;
    logic [RES_W:0]   int_mag;
    logic             rem_nz;
    logic [RES_W:0]   mag_fl;
    logic [RES_W:0]   neg_v;

    always_comb begin
        // magnitude at or above 2^RES_W: no range can hold it
        big       = (unp_i.expo >= EXP_LIM);
        shamt     = SH_W'(SIG_W - 1) - unp_i.expo[SH_W-1:0];
        keep_mask = {SIG_W{1'b1}} << shamt;

        if (unp_i.expo[EXP_W-1]) begin
            int_mag = '0;
            rem_nz  = |unp_i.sig;
        end else begin
            int_mag = (RES_W+1)'(unp_i.sig >> shamt);
            rem_nz  = |(unp_i.sig & ~keep_mask);
        end

        // floor of a negative value grows the magnitude when bits were lost
        mag_fl = int_mag + (RES_W+1)'(unp_i.sign & rem_nz);
        neg_v  = (RES_W+1)'(0) - mag_fl;

        res_o = '0;
        inv_o = 1'b0;
        inx_o = 1'b0;

        if (unp_i.is_nan) begin
            inv_o = 1'b1;
        end else if (!unp_i.sign) begin
            if (signed_i) begin
                if (unp_i.is_inf || big || (int_mag > MAG_SMAX)) begin
                    res_o = RES_SMAX;
                    inv_o = 1'b1;
                end else begin
                    res_o = int_mag[RES_W-1:0];
                    inx_o = rem_nz;
                end
            end else begin
                if (unp_i.is_inf || big) begin
                    res_o = RES_UMAX;
                    inv_o = 1'b1;
                end else begin
                    res_o = int_mag[RES_W-1:0];
                    inx_o = rem_nz;
                end
            end
        end else begin
            if (signed_i) begin
                if (unp_i.is_inf || big || (mag_fl > MAG_SMIN)) begin
                    res_o = RES_SMIN;
                    inv_o = 1'b1;
                end else begin
                    res_o = neg_v[RES_W-1:0];
                    inx_o = rem_nz;
                end
            end else begin
                if (unp_i.is_inf || big || (mag_fl != '0)) begin
                    inv_o = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fp_floor_cvt.sv
module fp_floor_cvt
    import fcvt_pkg::*;
#(
    parameter bit HALF_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [63:0] operand,
    input  logic [1:0]  fmt,
    input  logic        is_signed,
    output logic        out_valid,
    output logic [31:0] result,
    output logic        flag_invalid,
    output logic        flag_inexact,
    output logic        flag_badfmt
);

    unp_s             unp_h;
    unp_s             unp_s32;
    unp_s             unp_d;
    unp_s             unp_sel;
    logic             fmt_ok;
    logic [RES_W-1:0] core_res;
    logic             core_inv;
    logic             core_inx;
    out_s             st_d;
    out_s             st_q;

    generate
        if (HALF_EN) begin : g_half
            fcvt_field_split #(.EW(5), .FW(10)) u_half (
                .bits_i (operand[15:0]),
                .unp_o  (unp_h)
            );
        end else begin : g_no_half
            assign unp_h = '0;
        end
    endgenerate

    fcvt_field_split #(.EW(8), .FW(23)) u_single (
        .bits_i (operand[31:0]),
        .unp_o  (unp_s32)
    );

    fcvt_field_split #(.EW(11), .FW(52)) u_double (
        .bits_i (operand[OPD_W-1:0]),
        .unp_o  (unp_d)
    );

    always_comb begin
        unp_sel = unp_d;
        fmt_ok  = 1'b0;
        case (fmt)
            FMT_HALF: begin
                unp_sel = unp_h;
                fmt_ok  = HALF_EN;
            end
            FMT_SINGLE: begin
                unp_sel = unp_s32;
                fmt_ok  = 1'b1;
            end
            FMT_DOUBLE: begin
                unp_sel = unp_d;
                fmt_ok  = 1'b1;
            end
            default: begin
                unp_sel = unp_d;
                fmt_ok  = 1'b0;
            end
        endcase
    end

    fcvt_floor_core u_core (
        .unp_i    (unp_sel),
        .signed_i (is_signed),
        .res_o    (core_res),
        .inv_o    (core_inv),
        .inx_o    (core_inx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            if (!fmt_ok) begin
                st_d.bad = 1'b1;
                st_d.inv = 1'b0;
                st_d.inx = 1'b0;
            end else begin
                st_d.res = core_res;
                st_d.inv = core_inv;
                st_d.inx = core_inx;
                st_d.bad = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.vld;
    assign result       = st_q.res;
    assign flag_invalid = st_q.inv;
    assign flag_inexact = st_q.inx;
    assign flag_badfmt  = st_q.bad;

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(flag_invalid)));

    // R3
    badfmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !fmt_ok) |=> (flag_badfmt && result == $past(result)));

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_invalid && flag_inexact) && !(flag_badfmt && (flag_invalid || flag_inexact)));

    // R7
    nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt_ok && unp_sel.is_nan) |=> (result == '0 && flag_invalid));

    // R6
    unsigned_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt_ok && !is_signed && unp_sel.sign) |=> (result == '0));

endmodule

// File: tb/fp_floor_cvt_tb.sv
`timescale 1ns/1ps
module fp_floor_cvt_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] operand;
    logic [1:0]  fmt;
    logic        is_signed;

    logic        out_valid,  nh_valid;
    logic [31:0] result,     nh_result;
    logic        f_inv,      nh_inv;
    logic        f_inx,      nh_inx;
    logic        f_bad,      nh_bad;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fp_floor_cvt u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .fmt(fmt), .is_signed(is_signed), .out_valid(out_valid),
        .result(result), .flag_invalid(f_inv), .flag_inexact(f_inx),
        .flag_badfmt(f_bad)
    );

    fp_floor_cvt #(.HALF_EN(1'b0)) u_nohalf (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .fmt(fmt), .is_signed(is_signed), .out_valid(nh_valid),
        .result(nh_result), .flag_invalid(nh_inv), .flag_inexact(nh_inx),
        .flag_badfmt(nh_bad)
    );

    // {req[3:0], fmt[1:0], signed, operand[63:0], result[31:0], {invalid, inexact, badfmt}}
    localparam int NV = 32;
    localparam logic [105:0] VEC [NV] = '{
        {4'd4,  2'd1, 1'b1, 64'h0000_0000_0000_3E00, 32'h0000_0001, 3'b010}, // R4 half 1.5
        {4'd4,  2'd1, 1'b1, 64'h0000_0000_0000_BE00, 32'hFFFF_FFFE, 3'b010}, // R4 half -1.5
        {4'd2,  2'd1, 1'b0, 64'h0000_0000_0000_7BFF, 32'h0000_FFE0, 3'b000}, // R2 half max
        {4'd8,  2'd1, 1'b1, 64'h0000_0000_0000_7C00, 32'h7FFF_FFFF, 3'b100}, // R8 half +inf
        {4'd10, 2'd1, 1'b1, 64'h0000_0000_0000_0001, 32'h0000_0000, 3'b010}, // R10
        {4'd10, 2'd1, 1'b1, 64'h0000_0000_0000_8001, 32'hFFFF_FFFF, 3'b010}, // R10
        {4'd2,  2'd1, 1'b1, 64'hDEAD_BEEF_0000_3E00, 32'h0000_0001, 3'b010}, // R2 upper ignored
        {4'd9,  2'd2, 1'b1, 64'h0000_0000_4030_0000, 32'h0000_0002, 3'b010}, // R9 2.75
        {4'd4,  2'd2, 1'b1, 64'h0000_0000_C030_0000, 32'hFFFF_FFFD, 3'b010}, // R4 -2.75
        {4'd6,  2'd2, 1'b0, 64'h0000_0000_4F32_D05E, 32'hB2D0_5E00, 3'b000}, // R6 3e9
        {4'd5,  2'd2, 1'b1, 64'h0000_0000_4F32_D05E, 32'h7FFF_FFFF, 3'b100}, // R5 3e9 signed
        {4'd5,  2'd2, 1'b1, 64'h0000_0000_CF00_0000, 32'h8000_0000, 3'b000}, // R5 -2^31 exact
        {4'd5,  2'd2, 1'b1, 64'h0000_0000_4F00_0000, 32'h7FFF_FFFF, 3'b100}, // R5 2^31
        {4'd6,  2'd2, 1'b0, 64'h0000_0000_4F00_0000, 32'h8000_0000, 3'b000}, // R6 2^31 unsigned
        {4'd6,  2'd2, 1'b0, 64'h0000_0000_BF00_0000, 32'h0000_0000, 3'b100}, // R6 -0.5
        {4'd4,  2'd2, 1'b1, 64'h0000_0000_BF00_0000, 32'hFFFF_FFFF, 3'b010}, // R4 -0.5 signed
        {4'd6,  2'd2, 1'b0, 64'h0000_0000_8000_0000, 32'h0000_0000, 3'b000}, // R6 -0.0
        {4'd7,  2'd2, 1'b1, 64'h0000_0000_7FC0_0000, 32'h0000_0000, 3'b100}, // R7 qNaN
        {4'd7,  2'd2, 1'b0, 64'h0000_0000_7F80_0001, 32'h0000_0000, 3'b100}, // R7 sNaN
        {4'd8,  2'd2, 1'b1, 64'h0000_0000_FF80_0000, 32'h8000_0000, 3'b100}, // R8 -inf signed
        {4'd8,  2'd2, 1'b0, 64'h0000_0000_FF80_0000, 32'h0000_0000, 3'b100}, // R8 -inf unsigned
        {4'd9,  2'd3, 1'b1, 64'h4004_0000_0000_0000, 32'h0000_0002, 3'b010}, // R9 2.5
        {4'd4,  2'd3, 1'b1, 64'hC004_0000_0000_0000, 32'hFFFF_FFFD, 3'b010}, // R4 -2.5
        {4'd6,  2'd3, 1'b0, 64'h41EF_FFFF_FFE0_0000, 32'hFFFF_FFFF, 3'b000}, // R6 2^32-1
        {4'd6,  2'd3, 1'b0, 64'h41F0_0000_0000_0000, 32'hFFFF_FFFF, 3'b100}, // R6 2^32
        {4'd5,  2'd3, 1'b1, 64'hC1E0_0000_0010_0000, 32'h8000_0000, 3'b100}, // R5 -2^31-0.5
        {4'd5,  2'd3, 1'b1, 64'hC1E0_0000_0000_0000, 32'h8000_0000, 3'b000}, // R5 -2^31
        {4'd10, 2'd3, 1'b1, 64'h0000_0000_0000_0001, 32'h0000_0000, 3'b010}, // R10
        {4'd10, 2'd3, 1'b1, 64'h8000_0000_0000_0001, 32'hFFFF_FFFF, 3'b010}, // R10
        {4'd9,  2'd3, 1'b1, 64'h0000_0000_0000_0000, 32'h0000_0000, 3'b000}, // R9 zero
        {4'd9,  2'd2, 1'b1, 64'h0000_0000_4040_0000, 32'h0000_0003, 3'b000}, // R9 3.0
        {4'd2,  2'd2, 1'b1, 64'hFFFF_FFFF_4040_0000, 32'h0000_0003, 3'b000}  // R2 upper ignored
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp_v);
        n_run++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp_v);
        end
    endtask

    task automatic drive(input logic [1:0] f, input logic s, input logic [63:0] op);
        @(negedge clk);
        fmt       = f;
        is_signed = s;
        operand   = op;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    initial begin
        logic [31:0] prev;
        logic [31:0] nh_prev;
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        operand   = '0;
        fmt       = 2'd0;
        is_signed = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(11, "reset outputs", {27'd0, out_valid, result[3:0]}, 32'd0);
        check(11, "reset result", result, 32'd0);
        check(11, "reset flags", {29'd0, f_inv, f_inx, f_bad}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][101:100], VEC[i][99], VEC[i][98:35]);
            check(int'(VEC[i][105:102]), $sformatf("vector %0d result", i),
                  result, VEC[i][34:3]);
            check(int'(VEC[i][105:102]), $sformatf("vector %0d flags", i),
                  {29'd0, f_inv, f_inx, f_bad}, {29'd0, VEC[i][2:0]});
            // R1 one-cycle latency
            check(1, $sformatf("vector %0d out_valid", i), {31'd0, out_valid}, 32'd1);
        end

        // R3 format code 0 keeps the last result (3)
        drive(2'd0, 1'b1, 64'h0000_0000_4040_0000);
        check(3, "bad format result held", result, 32'd3);
        check(3, "bad format flags", {29'd0, f_inv, f_inx, f_bad}, 32'b001);
        check(3, "bad format out_valid", {31'd0, out_valid}, 32'd1);

        // R1 idle cycle: no valid, outputs hold
        prev = result;
        @(negedge clk);
        check(1, "idle out_valid", {31'd0, out_valid}, 32'd0);
        check(1, "idle result hold", result, prev);
        check(1, "idle flag hold", {29'd0, f_inv, f_inx, f_bad}, 32'b001);

        // R12 half disabled: code 1 acts as code 0
        drive(2'd2, 1'b1, 64'h0000_0000_40E0_0000); // 7.0 sets both instances
        check(12, "half-off setup", nh_result, 32'd7);
        nh_prev = nh_result;
        drive(2'd1, 1'b1, 64'h0000_0000_0000_3E00);
        check(12, "half-off result held", nh_result, nh_prev);
        check(12, "half-off badfmt", {29'd0, nh_inv, nh_inx, nh_bad}, 32'b001);
        check(2, "half-on converts", result, 32'd1);

        // R11 reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(11, "mid-run reset result", result, 32'd0);
        check(11, "mid-run reset flags", {28'd0, out_valid, f_inv, f_inx, f_bad}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule